// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Mapper

This block turns a 14-bit phase word into a 12-bit signed sine sample. It is meant to sit between a phase accumulator and a DAC, and it uses no large lookup memory. The top two phase bits give the quadrant. The lower twelve bits give an angle inside the quadrant. In the odd quadrants that angle is mirrored, so only the rising quarter of the wave is ever computed. The upper two quadrants negate the result.

The quarter-wave angle is cut into three 4-bit fields: coarse, middle and fine. Five sixteen-entry tables work from these fields. They hold the sine and cosine of the coarse step, the sine and cosine of the middle step, and the sine of the fine step. The table contents are computed when the design is elaborated and become plain combinational logic. The angle-addition identity joins the coarse and middle terms. The fine term is then added as a first-order correction, scaled by the combined cosine. The result is rounded to 11 magnitude bits, saturated, and given its sign.

The path has two register stages. A sample accepted on one clock edge shows up, with its valid flag, after the next edge.

Top module: `qsin_mapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `out_vld` and `out_amp` to 0 after that edge.
- R2: When `in_vld` is high at rising edge n, `out_vld` is high after edge n+1. When `in_vld` is low at edge n, `out_vld` is low after edge n+1. Samples leave in the order they arrived.
- R3: When no sample is completing, `out_amp` keeps its last value. A phase presented with `in_vld` low has no effect on the output.
- R4: For phase[13:12] = 00 and angle x = phase[11:0], `out_amp` lies within 1 LSB of min(round(2048·sin(π/2·(x+0.5)/4096)), 2047).
- R5: For phase[13:12] = 01, the output equals the quadrant-00 output for angle 4095−x. The match is exact.
- R6: For phase[13:12] = 10 and 11, the output is the exact negation of the output for 00 and 01 at the same angle.
- R7: The magnitude is saturated to 2047 and the value −2048 never appears. Phase 0x0FFF gives 2047, 0x1000 gives 2047, and 0x2FFF gives −2047.
- R8: A new sample is accepted on every clock edge, so back-to-back samples give one output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Phase sample valid |
| in_phase | input | 14 | Phase word: [13:12] quadrant, [11:0] angle |
| out_vld | output | 1 | Amplitude valid, two cycles after the input |
| out_amp | output | 12 | Signed two's-complement sine amplitude |

## Verification
The bench sweeps all 16384 phase words in order, presenting them back to back. After every seventh sample it inserts an idle cycle that carries a decoy phase. The sweep is compared against a floating-point sine computed in the bench. This tells accuracy and saturation faults apart from faults in quadrant folding. Folding faults are caught by exact comparison between the quadrant pairs, both mirrored and negated. The idle cycles separate valid-flag timing and output-hold faults from arithmetic faults. A single isolated sample placed right after reset checks the exact latency and the peak value.

// File: rtl/qsin_pkg.sv
package qsin_pkg;

  typedef enum logic [1:0] {
    TAB_COARSE = 2'd0,
    TAB_MID    = 2'd1,
    TAB_FINE   = 2'd2
  } tab_kind_e;

  // pi/2 in Q30
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // sine or cosine of (pi/2 * num / 2**shft), result in Q30, by Taylor series
  function automatic longint trig_q30(input bit use_cos, input longint num, input int shft);
    longint x;
    longint x2;
    longint term;
    longint acc;
    longint dv;
    x    = (HALF_PI_Q30 * num) >>> shft;
    x2   = (x * x) >>> 30;
    term = use_cos ? (longint'(1) <<< 30) : x;
    acc  = term;
    for (int k = 1; k <= 10; k++) begin
      dv   = use_cos ? longint'((2*k-1)*(2*k)) : longint'((2*k)*(2*k+1));
      term = -(((term * x2) >>> 30) / dv);
      acc  = acc + term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/qsin_fold.sv
module qsin_fold #(
  parameter int ANG_W = 12
) (
  input  logic [ANG_W+1:0] phase_i,
  output logic [ANG_W-1:0] ang_o,
  output logic             neg_o
);
  logic [1:0]       quad;
  logic [ANG_W-1:0] raw;

  assign quad  = phase_i[ANG_W+1:ANG_W];
  assign raw   = phase_i[ANG_W-1:0];
  // odd quadrants run backwards through the quarter wave
  assign ang_o = quad[0] ? ~raw : raw;
  // upper half of the cycle is negative
  assign neg_o = quad[1];
endmodule

// File: rtl/qsin_subtab.sv
module qsin_subtab
  import qsin_pkg::*;
#(
  parameter int        FLD_W   = 4,
  parameter int        TF      = 16,
  parameter tab_kind_e KIND    = TAB_COARSE,
  parameter bit        USE_COS = 1'b0
) (
  input  logic [FLD_W-1:0] idx_i,
  output logic [TF:0]      val_o
);
  localparam int TW  = TF + 1;
  localparam int N   = 1 << FLD_W;
  localparam int SHF = (KIND == TAB_COARSE) ? FLD_W :
                       (KIND == TAB_MID)    ? 2*FLD_W : 3*FLD_W + 1;

  logic [TW-1:0] tbl [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    // fine field is taken at the centre of its step
    localparam longint NUM = (KIND == TAB_FINE) ? longint'(2*gi + 1) : longint'(gi);
    localparam longint RAW = trig_q30(USE_COS, NUM, SHF);
    localparam longint RND = (RAW + (longint'(1) <<< (29 - TF))) >>> (30 - TF);
    localparam logic [TW-1:0] VAL = TW'(RND);
    assign tbl[gi] = VAL;
  end

  assign val_o = tbl[idx_i];
endmodule

// File: rtl/qsin_combine.sv
module qsin_combine #(
  parameter int TF    = 16,
  parameter int OUT_W = 12
) (
  input  logic [TF:0]      sa_i,
  input  logic [TF:0]      ca_i,
  input  logic [TF:0]      sb_i,
  input  logic [TF:0]      cb_i,
  input  logic [TF:0]      kc_i,
  output logic [OUT_W-2:0] mag_o,
  output logic             cab_sign_o
);
  localparam int TW = TF + 1;
  localparam int XW = 2*TW + 2;
  localparam int SH = 2*TF - (OUT_W - 1);
  localparam logic [XW-1:0] ONE  = {{(XW-1){1'b0}}, 1'b1};
  localparam logic [XW-1:0] RND  = ONE << (SH - 1);
  localparam logic [XW-1:0] MAXM = (ONE << (OUT_W - 1)) - ONE;

  logic [XW-1:0] sa_x, ca_x, sb_x, cb_x, kc_x;
  logic [XW-1:0] p_sacb, p_casb, p_cacb, p_sasb;
  logic [XW-1:0] cab, cab_q, term, sum, full;

  assign sa_x = {{(XW-TW){1'b0}}, sa_i};
  assign ca_x = {{(XW-TW){1'b0}}, ca_i};
  assign sb_x = {{(XW-TW){1'b0}}, sb_i};
  assign cb_x = {{(XW-TW){1'b0}}, cb_i};
  assign kc_x = {{(XW-TW){1'b0}}, kc_i};

  // sin(A+B) and cos(A+B) in Q(2*TF)
  assign p_sacb = sa_x * cb_x;
  assign p_casb = ca_x * sb_x;
  assign p_cacb = ca_x * cb_x;
  assign p_sasb = sa_x * sb_x;
  assign cab    = p_cacb - p_sasb;
  assign cab_sign_o = cab[XW-1];

  // first-order fine correction: cos(A+B) * sin(C)
  assign cab_q = cab >> TF;
  assign term  = cab_q * kc_x;

  assign sum  = p_sacb + p_casb + term + RND;
  assign full = sum >> SH;
  assign mag_o = (full > MAXM) ? MAXM[OUT_W-2:0] : full[OUT_W-2:0];
endmodule

// File: rtl/qsin_mapper.sv
module qsin_mapper
  import qsin_pkg::*;
#(
  parameter int FLD_W = 4,
  parameter int TF    = 16,
  parameter int OUT_W = 12,
  localparam int ANG_W   = 3*FLD_W,
  localparam int PHASE_W = ANG_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_amp
);
  localparam int TW   = TF + 1;
  localparam int NTAB = 5;

  logic [ANG_W-1:0] ang;
  logic             neg;
  logic [FLD_W-1:0] tidx [NTAB];
  logic [TW-1:0]    tv   [NTAB];
  logic [TW-1:0]    s1_tv [NTAB];
  logic             s1_vld, s1_neg;
  logic [OUT_W-2:0] mag;
  logic             cab_sign;

  qsin_fold #(.ANG_W(ANG_W)) u_fold (
    .phase_i (in_phase),
    .ang_o   (ang),
    .neg_o   (neg)
  );

  // table order: sin coarse, cos coarse, sin mid, cos mid, sin fine
  assign tidx[0] = ang[ANG_W-1 -: FLD_W];
  assign tidx[1] = ang[ANG_W-1 -: FLD_W];
  assign tidx[2] = ang[2*FLD_W-1 -: FLD_W];
  assign tidx[3] = ang[2*FLD_W-1 -: FLD_W];
  assign tidx[4] = ang[FLD_W-1:0];

  for (genvar gi = 0; gi < NTAB; gi++) begin : g_tab
    localparam tab_kind_e KND = (gi < 2) ? TAB_COARSE : ((gi < 4) ? TAB_MID : TAB_FINE);
    localparam bit        CS  = (gi == 1) || (gi == 3);
    qsin_subtab #(
      .FLD_W   (FLD_W),
      .TF      (TF),
      .KIND    (KND),
      .USE_COS (CS)
    ) u_tab (
      .idx_i (tidx[gi]),
      .val_o (tv[gi])
    );
  end

  // stage 1: table outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_neg <= 1'b0;
      for (int i = 0; i < NTAB; i++) s1_tv[i] <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_neg <= neg;
        for (int i = 0; i < NTAB; i++) s1_tv[i] <= tv[i];
      end
    end
  end

  qsin_combine #(.TF(TF), .OUT_W(OUT_W)) u_comb (
    .sa_i       (s1_tv[0]),
    .ca_i       (s1_tv[1]),
    .sb_i       (s1_tv[2]),
    .cb_i       (s1_tv[3]),
    .kc_i       (s1_tv[4]),
    .mag_o      (mag),
    .cab_sign_o (cab_sign)
  );

  // stage 2: signed output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_amp <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld)
        out_amp <= s1_neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_vld && out_amp == '0));
  p_stage_take_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> s1_vld);
  p_stage_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !s1_vld);
  p_out_take_r8: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_vld);
  p_out_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> !out_vld);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> $stable(out_amp));
  p_cos_pos_r4: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> !cab_sign);
  p_neg_half_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_neg) |=> (out_amp <= 0));
  p_pos_half_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_neg) |=> !out_amp[OUT_W-1]);
  p_no_minval_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_amp != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: tb/sim_qsin_mapper.sv
`timescale 1ns/1ps
module sim_qsin_mapper;
  localparam int PHW = 14;
  localparam int NPH = 1 << PHW;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_vld = 1'b0;
  logic [PHW-1:0]         in_phase = '0;
  logic                   out_vld;
  logic signed [11:0]     out_amp;

  qsin_mapper u0 (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_phase (in_phase),
    .out_vld  (out_vld),
    .out_amp  (out_amp)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int got  [NPH];
  bit seen [NPH];
  int pend [$];
  bit d0 = 1'b0;
  bit d1 = 1'b0;
  bit started = 1'b0;
  int last_amp = 0;

  function automatic int ref_amp(int p);
    int  q;
    int  x;
    int  r;
    real th;
    q = p >> 12;
    x = p & 4095;
    if (q & 1) x = 4095 - x;
    th = 1.5707963267948966 * (real'(x) + 0.5) / 4096.0;
    r = $rtoi(2048.0 * $sin(th) + 0.5);
    if (r > 2047) r = 2047;
    if (q & 2) r = -r;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic step(bit v, logic [PHW-1:0] ph);
    @(negedge clk);
    chk(out_vld == d1, "R2 valid latency", int'(out_vld), int'(d1));
    if (out_vld) begin
      if (pend.size() == 0) begin
        chk(1'b0, "R2 output with no pending sample", 1, 0);
      end else begin
        int p;
        p = pend.pop_front();
        got[p]  = int'(out_amp);
        seen[p] = 1'b1;
      end
      last_amp = int'(out_amp);
      started  = 1'b1;
    end else if (started) begin
      chk(int'(out_amp) == last_amp, "R3 hold while idle", int'(out_amp), last_amp);
    end
    in_vld   = v;
    in_phase = ph;
    if (v) pend.push_back(int'(ph));
    d1 = d0;
    d0 = v;
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int d;
    // R1: reset with a live input
    in_vld   = 1'b1;
    in_phase = 14'h0FFF;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 valid cleared in reset", int'(out_vld), 0);
    chk(out_amp == 0, "R1 amplitude cleared in reset", int'(out_amp), 0);
    rst    = 1'b0;
    in_vld = 1'b0;

    // R2 / R7: isolated sample at the peak
    step(1'b1, 14'h0FFF);
    step(1'b0, 14'h1555);
    step(1'b0, 14'h2AAA);
    chk(last_amp == 2047, "R7 isolated peak", last_amp, 2047);
    step(1'b0, 14'h3333);

    // R8 / R3: full sweep, back to back with a decoy idle cycle every seventh
    for (int i = 0; i < NPH; i++) begin
      step(1'b1, PHW'(i));
      if (i % 7 == 6) step(1'b0, 14'h2AAA);
    end
    repeat (4) step(1'b0, 14'h0000);
    chk(pend.size() == 0, "R8 all samples returned", pend.size(), 0);

    for (int p = 0; p < NPH; p++)
      chk(seen[p], "R8 sample present", int'(seen[p]), 1);

    // R4: accuracy of the first quadrant
    for (int x = 0; x < 4096; x++) begin
      d = got[x] - ref_amp(x);
      chk(d <= 1 && d >= -1, "R4 accuracy", got[x], ref_amp(x));
    end
    // R5: mirror symmetry
    for (int x = 0; x < 4096; x++)
      chk(got[4096 + x] == got[4095 - x], "R5 mirror", got[4096 + x], got[4095 - x]);
    // R6: negation of the lower half
    for (int x = 0; x < 8192; x++)
      chk(got[8192 + x] == -got[x], "R6 negation", got[8192 + x], -got[x]);
    // R7: range and saturation points
    for (int p = 0; p < NPH; p++)
      chk(got[p] >= -2047 && got[p] <= 2047, "R7 range", got[p], 2047);
    chk(got[14'h0FFF] == 2047,  "R7 top of quadrant 0", got[14'h0FFF], 2047);
    chk(got[14'h1000] == 2047,  "R7 start of quadrant 1", got[14'h1000], 2047);
    chk(got[14'h2FFF] == -2047, "R7 bottom of quadrant 2", got[14'h2FFF], -2047);
    chk(got[0] == ref_amp(0),   "R4 zero phase", got[0], ref_amp(0));

    summary();
    $finish;
  end
endmodule